// File: doc/BRIEF.md
# Chainable Periodic Interrupt Timer

This block is a bank of down-counting periodic timers behind a plain word-addressed read/write strobe interface. Each channel counts down from a programmable load value, reloads when it passes zero, and raises a sticky expiry flag. The flag drives that channel's interrupt line when the channel's interrupt enable is set. A channel can be placed in chain mode. It then counts only in cycles where the channel below it expires. Chaining channel 1 onto channel 0 gives a 64-bit lifetime counter. It is read high word first. That read captures channel 0's count into a shadow register, so the low-word read that follows matches it.

One module control word stops every channel (the disable bit) or halts them while the external debug-halt input is high (the freeze bit). Each channel follows a two-state machine. In `CH_IDLE` the counter holds. A control write with the enable bit set takes the transition `START` to `CH_RUN` and loads the counter from the load value. In `CH_RUN` the counter decrements on every qualified tick. A control write with the enable bit clear takes the transition `STOP` back to `CH_IDLE`.

Top module: `chain_pit`

## Requirements
- R1: After reset the module disable bit (word 0 bit 0) reads 1, the freeze bit (word 0 bit 1) reads 0, every channel control word and flag word reads 0, and every interrupt line is low.
- R2: While the disable bit is 1, no channel counter changes except through a `START` load. In the cycle after the disable bit is cleared, counting resumes.
- R3: While the freeze bit is 1 and `dbg_halt` is high, no counter changes. With the freeze bit at 0, counters keep running while `dbg_halt` is high.
- R4: Channel c's control word sits at word 4+4c+2, with bit 0 enable, bit 1 interrupt enable and bit 2 chain. Writing enable=1 to a disabled channel loads the counter from its load value (word 4+4c). Writing enable=1 to a running channel does not reload it.
- R5: A running channel decrements once per tick. A tick that finds the counter at zero reloads the load value and sets the channel flag (word 4+4c+3, bit 0).
- R6: Writing 1 to flag bit 0 clears the flag, and an expiry in the same cycle wins. Interrupt line c is high exactly when flag c and interrupt enable c are both 1.
- R7: A load-value write does not alter a running counter. The new value is used at the next reload or start.
- R8: A chained channel c>0 ticks only in cycles where channel c-1 expires, so channel 1 chained with loads L0 and L1 sets its flag (L0+1)(L1+1) ticks after start. The chain bit of channel 0 has no effect.
- R9: A read of word 1 returns channel 1's count and copies channel 0's count into a shadow register. A read of word 2 returns the shadow register.
- R10: Word 4+4c+1 returns channel c's live counter, and reading it changes no state.
- R11: `bus_rdata` holds the addressed word one cycle after a `bus_rd` strobe and keeps it until the next strobe. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_halt | input | 1 | Debug halt request, acted on when the freeze bit is set |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt requests |

## Verification
Every register, including each counter, updates at the edge where a write strobe or a tick is sampled. The bench drives inputs on the falling edge, so a write's effect is visible half a cycle later. `bus_rdata` reflects the pre-edge state of the sampled edge, and interrupt lines follow the flag at that same edge. A behavioural model in the bench steps at each rising edge from the same inputs and is compared with `irq` and `bus_rdata` at every falling edge. Directed checks add hand-computed values at those same points, for example the chained flag rising exactly at the twelfth edge after the run starts.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;

    typedef struct packed {
        logic chain;
        logic irq_en;
        logic enable;
    } ch_ctrl_t;

    localparam int REG_MCTL  = 0;
    localparam int REG_LT_HI = 1;
    localparam int REG_LT_LO = 2;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int OFF_LOAD  = 0;
    localparam int OFF_VALUE = 1;
    localparam int OFF_CTRL  = 2;
    localparam int OFF_FLAG  = 3;

endpackage

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit HAS_PREV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             prev_expire,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_data,
    input  logic             ctrl_we,
    input  ch_ctrl_t         ctrl_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output ch_ctrl_t         ctrl_q,
    output logic             flag_q,
    output logic             expire,
    output logic             irq
);

    ch_state_t state_q, state_d;
    logic      irq_en_q, chain_q;
    logic      start, tick, use_chain;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctrl_we && ctrl_data.enable)  state_d = CH_RUN;
            CH_RUN:  if (ctrl_we && !ctrl_data.enable) state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    assign start     = (state_q == CH_IDLE) && (state_d == CH_RUN);
    assign use_chain = HAS_PREV && chain_q;
    assign tick      = (state_q == CH_RUN) && run && (use_chain ? prev_expire : 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= '0;
            cnt_q    <= '0;
            flag_q   <= 1'b0;
            irq_en_q <= 1'b0;
            chain_q  <= 1'b0;
        end else begin
            if (load_we) load_q <= load_data;
            if (ctrl_we) begin
                irq_en_q <= ctrl_data.irq_en;
                chain_q  <= ctrl_data.chain;
            end
            if (start)
                cnt_q <= load_q;
            else if (tick)
                cnt_q <= (cnt_q == '0) ? load_q : cnt_q - 1'b1;
            if (tick && cnt_q == '0) flag_q <= 1'b1;
            else if (flag_clr)       flag_q <= 1'b0;
        end
    end

    always_comb begin
        expire        = tick && (cnt_q == '0);
        irq           = flag_q && irq_en_q;
        ctrl_q.enable = (state_q == CH_RUN);
        ctrl_q.irq_en = irq_en_q;
        ctrl_q.chain  = chain_q;
    end

endmodule

// File: rtl/pit_lifetime.sv
module pit_lifetime #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_read,
    input  logic [CNT_W-1:0] low_cnt,
    output logic [CNT_W-1:0] shadow_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (hi_read) shadow_q <= low_cnt;
    end

endmodule

// File: rtl/chain_pit.sv
module chain_pit
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic                          mdis_q, frz_q, run;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all, load_all;
    logic [NUM_CH-1:0]             flag_all, en_all, chn_all, ie_all, exp_all;
    logic [CNT_W-1:0]              shadow_q, rd_mux;
    logic                          hi_read;
    ch_ctrl_t                      wr_ctrl;

    assign wr_ctrl = ch_ctrl_t'(bus_wdata[2:0]);
    assign run     = !mdis_q && !(frz_q && dbg_halt);
    assign hi_read = bus_rd && (bus_addr == ADDR_W'(REG_LT_HI));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdis_q <= 1'b1;
            frz_q  <= 1'b0;
        end else if (bus_wr && bus_addr == ADDR_W'(REG_MCTL)) begin
            mdis_q <= bus_wdata[0];
            frz_q  <= bus_wdata[1];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * c;
        ch_ctrl_t ctrl_c;
        logic     prev_exp;

        if (c == 0) begin : g_first
            assign prev_exp = 1'b0;
        end else begin : g_next
            assign prev_exp = exp_all[c-1];
        end

        pit_channel #(
            .CNT_W    (CNT_W),
            .HAS_PREV (c > 0)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run),
            .prev_expire (prev_exp),
            .load_we     (bus_wr && bus_addr == ADDR_W'(BASE + OFF_LOAD)),
            .load_data   (bus_wdata),
            .ctrl_we     (bus_wr && bus_addr == ADDR_W'(BASE + OFF_CTRL)),
            .ctrl_data   (wr_ctrl),
            .flag_clr    (bus_wr && bus_addr == ADDR_W'(BASE + OFF_FLAG) && bus_wdata[0]),
            .load_q      (load_all[c]),
            .cnt_q       (cnt_all[c]),
            .ctrl_q      (ctrl_c),
            .flag_q      (flag_all[c]),
            .expire      (exp_all[c]),
            .irq         (irq[c])
        );

        assign en_all[c]  = ctrl_c.enable;
        assign ie_all[c]  = ctrl_c.irq_en;
        assign chn_all[c] = ctrl_c.chain;
    end

    pit_lifetime #(.CNT_W(CNT_W)) u_life (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_read  (hi_read),
        .low_cnt  (cnt_all[0]),
        .shadow_q (shadow_q)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(REG_MCTL))  rd_mux = {{(CNT_W-2){1'b0}}, frz_q, mdis_q};
        if (bus_addr == ADDR_W'(REG_LT_HI)) rd_mux = cnt_all[1];
        if (bus_addr == ADDR_W'(REG_LT_LO)) rd_mux = shadow_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_LOAD))  rd_mux = load_all[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_VALUE)) rd_mux = cnt_all[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CTRL))
                rd_mux = {{(CNT_W-3){1'b0}}, chn_all[c], ie_all[c], en_all[c]};
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_FLAG))
                rd_mux = {{(CNT_W-1){1'b0}}, flag_all[c]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dbg_halt,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [CNT_W-1:0]             bus_wdata,
    input logic                         mdis_q,
    input logic                         frz_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_CH-1:0][CNT_W-1:0] load_all,
    input logic [NUM_CH-1:0]            flag_all,
    input logic [NUM_CH-1:0]            en_all,
    input logic [NUM_CH-1:0]            chn_all,
    input logic [CNT_W-1:0]             shadow_q
);

    AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mdis_q && !bus_wr) |=> $stable(cnt_all)); // R2

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && dbg_halt && !bus_wr) |=> $stable(cnt_all)); // R3

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CH_BASE + OFF_CTRL) && bus_wdata[0] && !en_all[0])
        |=> (cnt_all[0] == $past(load_all[0]))); // R4

    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdis_q && !(frz_q && dbg_halt) && en_all[0] && cnt_all[0] == '0 && !bus_wr)
        |=> (cnt_all[0] == $past(load_all[0]) && flag_all[0])); // R5

    AST_FLAG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_all[0]) |-> ($past(cnt_all[0]) == '0)); // R5

    AST_CHAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (chn_all[1] && en_all[1] && cnt_all[0] != '0 && !bus_wr) |=> $stable(cnt_all[1])); // R8

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(REG_LT_HI)) |=> (shadow_q == $past(cnt_all[0]))); // R9

endmodule

bind chain_pit pit_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_halt  (dbg_halt),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mdis_q    (mdis_q),
    .frz_q     (frz_q),
    .cnt_all   (cnt_all),
    .load_all  (load_all),
    .flag_all  (flag_all),
    .en_all    (en_all),
    .chn_all   (chn_all),
    .shadow_q  (shadow_q)
);

// File: tb/sim_chain_pit.sv
`timescale 1ns/1ps
module sim_chain_pit;

    localparam int NCH = 4;
    localparam int AW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dbg_halt = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    chain_pit #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference state
    int unsigned m_cnt[NCH], m_load[NCH];
    bit          m_en[NCH], m_ie[NCH], m_chn[NCH], m_flag[NCH];
    bit          m_mdis, m_frz;
    int unsigned m_shadow, m_rdata;

    function automatic int unsigned m_read(input int a);
        if (a == 0) return {30'd0, m_frz, m_mdis};
        if (a == 1) return m_cnt[1];
        if (a == 2) return m_shadow;
        if (a >= 4 && a < 4 + 4 * NCH) begin
            case ((a - 4) % 4)
                0: return m_load[(a - 4) / 4];
                1: return m_cnt[(a - 4) / 4];
                2: return {29'd0, m_chn[(a-4)/4], m_ie[(a-4)/4], m_en[(a-4)/4]};
                default: return {31'd0, m_flag[(a - 4) / 4]};
            endcase
        end
        return 0;
    endfunction

    always @(posedge clk) begin : model
        bit          run;
        bit          ex[NCH];
        bit          tk;
        int unsigned ncnt[NCH];
        bit          nflag[NCH];
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_load[c] = 0; m_en[c] = 0;
                m_ie[c] = 0; m_chn[c] = 0; m_flag[c] = 0;
            end
            m_mdis = 1; m_frz = 0; m_shadow = 0; m_rdata = 0;
        end else begin
            run = !m_mdis && !(m_frz && dbg_halt);
            for (int c = 0; c < NCH; c++) begin
                tk       = run && m_en[c] && ((c > 0 && m_chn[c]) ? ex[c-1] : 1'b1);
                ex[c]    = tk && m_cnt[c] == 0;
                ncnt[c]  = tk ? (m_cnt[c] == 0 ? m_load[c] : m_cnt[c] - 1) : m_cnt[c];
                nflag[c] = m_flag[c] | ex[c];
            end
            if (bus_rd) begin
                m_rdata = m_read(int'(bus_addr));
                if (bus_addr == 1) m_shadow = m_cnt[0];
            end
            if (bus_wr) begin
                if (bus_addr == 0) begin
                    m_mdis = bus_wdata[0];
                    m_frz  = bus_wdata[1];
                end else if (bus_addr >= 4 && int'(bus_addr) < 4 + 4 * NCH) begin
                    case ((int'(bus_addr) - 4) % 4)
                        0: m_load[(bus_addr - 4) / 4] = bus_wdata;
                        2: begin
                            if (bus_wdata[0] && !m_en[(bus_addr - 4) / 4])
                                ncnt[(bus_addr - 4) / 4] = m_load[(bus_addr - 4) / 4];
                            m_en[(bus_addr - 4) / 4]  = bus_wdata[0];
                            m_ie[(bus_addr - 4) / 4]  = bus_wdata[1];
                            m_chn[(bus_addr - 4) / 4] = bus_wdata[2];
                        end
                        3: if (bus_wdata[0] && !ex[(bus_addr - 4) / 4])
                               nflag[(bus_addr - 4) / 4] = 1'b0;
                        default: ;
                    endcase
                end
            end
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c]  = ncnt[c];
                m_flag[c] = nflag[c];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++)
                chk(irq[c] == (m_flag[c] && m_ie[c]), "R6 irq vs model", 32'(irq[c]),
                    32'(m_flag[c] && m_ie[c]));
            chk(bus_rdata == m_rdata, "R11 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        summary();
    end

    initial begin : stim
        logic [31:0] v, v2, h, l;
        bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v);  chk(v == 32'h1, "R1 module control reset", v, 32'h1);
        rd(6, v);  chk(v == 0, "R1 ch0 control reset", v, 0);
        rd(7, v);  chk(v == 0, "R1 ch0 flag reset", v, 0);
        rd(10, v); chk(v == 0, "R1 ch1 control reset", v, 0);
        chk(irq == 0, "R1 irq reset", 32'(irq), 0);

        // R4 start load while module disabled, R2 hold
        wr(4, 5); wr(6, 3);
        rd(5, v); chk(v == 5, "R4 start loads counter", v, 5);
        rd(6, v); chk(v == 3, "R4 control bits", v, 3);
        repeat (4) @(negedge clk);
        rd(5, v); chk(v == 5, "R2 disabled holds count", v, 5);

        // R5 run to expiry
        wr(0, 0);
        got = 0;
        for (int i = 0; i < 50 && !got; i++) begin
            @(negedge clk);
            got = irq[0];
        end
        chk(got, "R5 expiry raises flag and irq", 32'(got), 1);
        wr(0, 1);
        rd(7, v); chk(v == 1, "R5 flag set", v, 1);
        wr(7, 1);
        rd(7, v); chk(v == 0, "R6 write-one clears flag", v, 0);
        chk(irq[0] == 0, "R6 irq low after clear", 32'(irq[0]), 0);

        // R6 gating: flag without irq enable
        wr(6, 1); wr(0, 0);
        got = 0;
        for (int i = 0; i < 30 && !got; i++) begin
            rd(7, v);
            got = v[0];
        end
        chk(got, "R6 flag set with irq disabled", 32'(got), 1);
        chk(irq[0] == 0, "R6 irq masked", 32'(irq[0]), 0);
        wr(0, 1); wr(7, 1);

        // R7 load write does not disturb count
        rd(5, v); wr(4, 9); rd(5, v2);
        chk(v2 == v, "R7 load write keeps count", v2, v);
        rd(4, v); chk(v == 9, "R7 load value stored", v, 9);

        // R3 freeze
        dbg_halt = 1'b1;
        wr(0, 2);
        rd(5, v); rd(5, v2);
        chk(v2 == v, "R3 frozen in debug", v2, v);
        wr(0, 0);
        rd(5, v); rd(5, v2);
        chk(v2 != v, "R3 runs in debug without freeze", v2, v);
        dbg_halt = 1'b0;

        // R10 reads have no side effect
        wr(0, 1);
        rd(5, v); rd(5, v2);
        chk(v2 == v, "R10 repeated value reads", v2, v);
        rd(7, v2);
        chk(v2 == 0, "R10 value read left flag", v2, 0);

        // R8 chain ch1 to ch0: loads 3 and 2 -> 12 ticks
        wr(6, 0); wr(7, 1); wr(4, 3); wr(8, 2); wr(10, 7); wr(6, 3);
        wr(0, 0);
        repeat (11) @(negedge clk);
        chk(irq[1] == 0, "R8 chained flag not before product", 32'(irq[1]), 0);
        @(negedge clk);
        chk(irq[1] == 1, "R8 chained flag at product", 32'(irq[1]), 1);

        // R9 lifetime read
        rd(1, h); repeat (3) @(negedge clk); rd(2, l);
        wr(0, 1);
        rd(5, v); rd(1, h); rd(9, v2);
        chk(h == v2, "R9 high word is ch1 count", h, v2);
        rd(2, l);
        chk(l == v, "R9 low word is shadowed ch0", l, v);

        // R8 ch0 chain bit ignored
        wr(6, 7); wr(0, 0);
        rd(5, v); rd(5, v2);
        chk(v2 != v, "R8 ch0 chain bit no effect", v2, v);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule